// File: doc/BRIEF.md
# Quadrature Encoder Input Conditioner and Count Decoder

This block sits between four encoder pins (two phase channels, an index mark and a strobe mark) and a position counter. Each pin can be inverted on its own, and the two phase channels can be exchanged, before any decoding takes place. The conditioned phase pair is then decoded into a one-cycle count pulse with a direction bit. The decoding follows one of four count modes: full quadrature, clock-plus-direction, count-up and count-down. The index and strobe marks are passed on as conditioned levels, with single-cycle rising and falling edge pulses that latch logic further down can use.

All configuration comes from one static 16-bit control word. The pins are expected to be synchronous to `clk` already. Every output is registered. After reset the block first collects two fresh input samples, and only then may it produce any pulse, so the reset value of its history registers never turns into a false count or a false edge.

Top module: `qdec_frontend`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output (count pulse, direction, phase error, both levels and all four edge pulses) is low.
- R2: Control word fields are: count mode in bits 15:14 (0 quadrature, 1 clock-plus-direction, 2 up, 3 down), rising-only in bit 11, A/B exchange in bit 10, and inversion of A, B, index and strobe in bits 8, 7, 6 and 5. All other bits have no effect on any output.
- R3: In quadrature mode each single-channel step of the sequence {A,B} = 00, 10, 11, 01, 00 (A leads B) gives exactly one count pulse with direction 1 (up).
- R4: In quadrature mode each single-channel step of the reverse sequence (B leads A) gives one count pulse with direction 0 (down).
- R5: In quadrature mode a sample where A and B both change gives no count pulse and a one-cycle phase-error pulse. Phase error never rises in the other modes and never coincides with a count pulse.
- R6: In mode 1 every qualifying edge of A gives a count pulse, and the direction is the level of B in that same sample (1 = up).
- R7: In mode 2 every qualifying edge of A counts up, and in mode 3 it counts down. B has no effect in either mode.
- R8: In modes 1 to 3, a rising-only bit of 0 counts both edges of A, and a rising-only bit of 1 counts only rising edges of A. In quadrature mode the bit has no effect.
- R9: Each inversion bit flips its pin before decoding and before edge detection. An inverted level is seen at the outputs as the opposite level.
- R10: The exchange bit swaps A and B after inversion, so an A-leads-B pin sequence counts down in quadrature mode.
- R11: The index and strobe outputs give the conditioned level, plus a rising pulse and a falling pulse that each last one cycle per change.
- R12: A pin sample taken at clock edge N shows at the outputs after edge N+1. No count, phase error or edge pulse comes from the first sample taken after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | CTRL_W (16) | Static decoder configuration |
| enc_a | input | 1 | Phase channel A pin |
| enc_b | input | 1 | Phase channel B pin |
| enc_idx | input | 1 | Index mark pin |
| enc_stb | input | 1 | Strobe mark pin |
| cnt_pulse | output | 1 | One-cycle count request |
| cnt_dir | output | 1 | Direction of the last count (1 = up) |
| phase_err | output | 1 | One-cycle illegal quadrature step flag |
| idx_lvl | output | 1 | Conditioned index level |
| idx_rise | output | 1 | Index rising-edge pulse |
| idx_fall | output | 1 | Index falling-edge pulse |
| stb_lvl | output | 1 | Conditioned strobe level |
| stb_rise | output | 1 | Strobe rising-edge pulse |
| stb_fall | output | 1 | Strobe falling-edge pulse |

## Verification
Each pin pattern is driven on a falling clock edge and captured at the next rising edge. Its count pulse, phase error, level and edge results are registered one rising edge after that, so they are due two rising edges after the pattern is driven. The driver marks each expected result with the monitor slot it falls due in, two slots ahead. The monitor samples one nanosecond after each rising edge and compares only the result that is due in that slot. Control word changes are wrapped in quiet cycles with steady pins, so a result is never decoded under a setting other than the one it was predicted with.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  localparam int CFG_MODE_HI  = 15;
  localparam int CFG_MODE_LO  = 14;
  localparam int CFG_RISE_BIT = 11;
  localparam int CFG_SWAP_BIT = 10;
  localparam int CFG_POLA_BIT = 8;
  localparam int CFG_POLB_BIT = 7;
  localparam int CFG_POLI_BIT = 6;
  localparam int CFG_POLS_BIT = 5;
  localparam int CFG_MIN_W    = 16;

  // pin lane order inside the block: 0 = A, 1 = B, 2 = index, 3 = strobe
  localparam int LANE_A   = 0;
  localparam int LANE_B   = 1;
  localparam int LANE_IDX = 2;
  localparam int LANE_STB = 3;
  localparam int NLANES   = 4;

  typedef enum logic [1:0] {
    QM_QUAD   = 2'd0,
    QM_DIRCLK = 2'd1,
    QM_UP     = 2'd2,
    QM_DOWN   = 2'd3
  } qmode_e;

  typedef struct packed {
    qmode_e              mode;
    logic                rise_only;
    logic                swap_ab;
    logic [NLANES-1:0]   invert;
  } qcfg_t;

  function automatic qcfg_t cfg_from_word(input logic [CFG_MIN_W-1:0] w);
    qcfg_t c;
    c.mode              = qmode_e'(w[CFG_MODE_HI:CFG_MODE_LO]);
    c.rise_only         = w[CFG_RISE_BIT];
    c.swap_ab           = w[CFG_SWAP_BIT];
    c.invert[LANE_A]    = w[CFG_POLA_BIT];
    c.invert[LANE_B]    = w[CFG_POLB_BIT];
    c.invert[LANE_IDX]  = w[CFG_POLI_BIT];
    c.invert[LANE_STB]  = w[CFG_POLS_BIT];
    return c;
  endfunction

  function automatic logic [CFG_MIN_W-1:0] cfg_used_mask();
    logic [CFG_MIN_W-1:0] m;
    m = '0;
    m[CFG_MODE_HI]  = 1'b1;
    m[CFG_MODE_LO]  = 1'b1;
    m[CFG_RISE_BIT] = 1'b1;
    m[CFG_SWAP_BIT] = 1'b1;
    m[CFG_POLA_BIT] = 1'b1;
    m[CFG_POLB_BIT] = 1'b1;
    m[CFG_POLI_BIT] = 1'b1;
    m[CFG_POLS_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/qdec_condition.sv
module qdec_condition #(
  parameter int NIN = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NIN-1:0] raw_in,
  input  logic [NIN-1:0] invert,
  input  logic           swap_ab,
  output logic [NIN-1:0] cur_q,
  output logic [NIN-1:0] prv_q,
  output logic           hist_ok
);
  import qdec_pkg::*;

  logic [NIN-1:0] flipped;
  logic [NIN-1:0] routed;
  logic           seen_one;

  // per-lane polarity
  for (genvar g = 0; g < NIN; g++) begin : g_inv
    assign flipped[g] = raw_in[g] ^ invert[g];
  end

  // optional exchange of the two phase lanes
  always_comb begin
    routed = flipped;
    if (swap_ab) begin
      routed[LANE_A] = flipped[LANE_B];
      routed[LANE_B] = flipped[LANE_A];
    end
  end

  // sample and one-deep history; hist_ok once both hold real samples
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      prv_q    <= '0;
      seen_one <= 1'b0;
      hist_ok  <= 1'b0;
    end else begin
      cur_q    <= routed;
      prv_q    <= cur_q;
      seen_one <= 1'b1;
      hist_ok  <= seen_one;
    end
  end

endmodule

// File: rtl/qdec_count_decode.sv
module qdec_count_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  qmode_e     mode,
  input  logic       rise_only,
  input  logic [1:0] cur_ab,
  input  logic [1:0] prv_ab,
  input  logic       hist_ok,
  output logic       pulse_q,
  output logic       dir_q,
  output logic       err_q
);

  logic a_chg, b_chg, a_up, a_dn, a_qual;
  logic nx_pulse, nx_dir, nx_err;

  assign a_chg  = cur_ab[0] ^ prv_ab[0];
  assign b_chg  = cur_ab[1] ^ prv_ab[1];
  assign a_up   = cur_ab[0] & ~prv_ab[0];
  assign a_dn   = ~cur_ab[0] & prv_ab[0];
  assign a_qual = rise_only ? a_up : (a_up | a_dn);

  always_comb begin
    nx_pulse = 1'b0;
    nx_dir   = dir_q;
    nx_err   = 1'b0;
    unique case (mode)
      QM_QUAD: begin
        if (a_chg && b_chg) begin
          nx_err = 1'b1;
        end else if (a_chg || b_chg) begin
          nx_pulse = 1'b1;
          nx_dir   = cur_ab[0] ^ prv_ab[1];
        end
      end
      QM_DIRCLK: begin
        nx_pulse = a_qual;
        if (a_qual) nx_dir = cur_ab[1];
      end
      QM_UP: begin
        nx_pulse = a_qual;
        if (a_qual) nx_dir = 1'b1;
      end
      QM_DOWN: begin
        nx_pulse = a_qual;
        if (a_qual) nx_dir = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      dir_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pulse_q <= nx_pulse & hist_ok;
      err_q   <= nx_err & hist_ok;
      if (hist_ok) dir_q <= nx_dir;
    end
  end

endmodule

// File: rtl/qdec_edge_pair.sv
module qdec_edge_pair #(
  parameter int NSIG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSIG-1:0] cur,
  input  logic [NSIG-1:0] prv,
  input  logic            hist_ok,
  output logic [NSIG-1:0] lvl_q,
  output logic [NSIG-1:0] rise_q,
  output logic [NSIG-1:0] fall_q
);

  for (genvar g = 0; g < NSIG; g++) begin : g_mark
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q[g]  <= 1'b0;
        rise_q[g] <= 1'b0;
        fall_q[g] <= 1'b0;
      end else begin
        lvl_q[g]  <= cur[g];
        rise_q[g] <= hist_ok & cur[g] & ~prv[g];
        fall_q[g] <= hist_ok & ~cur[g] & prv[g];
      end
    end
  end

endmodule

// File: rtl/qdec_frontend.sv
module qdec_frontend #(
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_idx,
  input  logic              enc_stb,
  output logic              cnt_pulse,
  output logic              cnt_dir,
  output logic              phase_err,
  output logic              idx_lvl,
  output logic              idx_rise,
  output logic              idx_fall,
  output logic              stb_lvl,
  output logic              stb_rise,
  output logic              stb_fall
);
  import qdec_pkg::*;

  localparam int NMARK = NLANES - 2;
  localparam logic [CTRL_W-1:0] USED = CTRL_W'(cfg_used_mask());

  qcfg_t             cfg;
  logic [NLANES-1:0] raw, cur, prv;
  logic              hist_ok;
  logic [NMARK-1:0]  m_lvl, m_rise, m_fall;
  logic              ctrl_unused;

  assign cfg         = cfg_from_word(ctrl_word[CFG_MIN_W-1:0]);
  assign ctrl_unused = ^(ctrl_word & ~USED);

  assign raw[LANE_A]   = enc_a;
  assign raw[LANE_B]   = enc_b;
  assign raw[LANE_IDX] = enc_idx;
  assign raw[LANE_STB] = enc_stb;

  qdec_condition #(.NIN(NLANES)) u_cond (
    .clk     (clk),
    .rst     (rst),
    .raw_in  (raw),
    .invert  (cfg.invert),
    .swap_ab (cfg.swap_ab),
    .cur_q   (cur),
    .prv_q   (prv),
    .hist_ok (hist_ok)
  );

  qdec_count_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .mode      (cfg.mode),
    .rise_only (cfg.rise_only),
    .cur_ab    (cur[LANE_B:LANE_A]),
    .prv_ab    (prv[LANE_B:LANE_A]),
    .hist_ok   (hist_ok),
    .pulse_q   (cnt_pulse),
    .dir_q     (cnt_dir),
    .err_q     (phase_err)
  );

  qdec_edge_pair #(.NSIG(NMARK)) u_marks (
    .clk     (clk),
    .rst     (rst),
    .cur     (cur[LANE_STB:LANE_IDX]),
    .prv     (prv[LANE_STB:LANE_IDX]),
    .hist_ok (hist_ok),
    .lvl_q   (m_lvl),
    .rise_q  (m_rise),
    .fall_q  (m_fall)
  );

  assign idx_lvl  = m_lvl[0];
  assign idx_rise = m_rise[0];
  assign idx_fall = m_fall[0];
  assign stb_lvl  = m_lvl[1];
  assign stb_rise = m_rise[1];
  assign stb_fall = m_fall[1];

endmodule

// File: rtl/qdec_frontend_chk.sv
module qdec_frontend_chk #(
  parameter int CTRL_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              cnt_pulse,
  input logic              cnt_dir,
  input logic              phase_err,
  input logic              idx_lvl,
  input logic              idx_rise,
  input logic              idx_fall,
  input logic              stb_lvl,
  input logic              stb_rise,
  input logic              stb_fall
);
  import qdec_pkg::*;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cnt_pulse && !phase_err && !idx_rise && !idx_fall && !stb_rise && !stb_fall));

  // R5
  pulse_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cnt_pulse && phase_err));

  // R5
  err_quad_only_chk: assert property (@(posedge clk) disable iff (rst)
    phase_err |-> ($past(ctrl_word[CFG_MODE_HI:CFG_MODE_LO]) == 2'd0));

  // R7
  up_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_pulse && $past(ctrl_word[CFG_MODE_HI:CFG_MODE_LO]) == 2'd2) |-> cnt_dir);

  // R7
  down_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_pulse && $past(ctrl_word[CFG_MODE_HI:CFG_MODE_LO]) == 2'd3) |-> !cnt_dir);

  // R11
  idx_rise_chk: assert property (@(posedge clk) disable iff (rst)
    idx_rise |-> (idx_lvl && !$past(idx_lvl)));

  // R11
  idx_fall_chk: assert property (@(posedge clk) disable iff (rst)
    idx_fall |-> (!idx_lvl && $past(idx_lvl)));

  // R11
  stb_rise_chk: assert property (@(posedge clk) disable iff (rst)
    stb_rise |-> (stb_lvl && !$past(stb_lvl)));

  // R11
  stb_fall_chk: assert property (@(posedge clk) disable iff (rst)
    stb_fall |-> (!stb_lvl && $past(stb_lvl)));

  // R11
  idx_single_chk: assert property (@(posedge clk) disable iff (rst)
    idx_rise |=> !idx_rise);

endmodule

bind qdec_frontend qdec_frontend_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctrl_word (ctrl_word),
  .cnt_pulse (cnt_pulse),
  .cnt_dir   (cnt_dir),
  .phase_err (phase_err),
  .idx_lvl   (idx_lvl),
  .idx_rise  (idx_rise),
  .idx_fall  (idx_fall),
  .stb_lvl   (stb_lvl),
  .stb_rise  (stb_rise),
  .stb_fall  (stb_fall)
);

// File: tb/qdec_frontend_bench.sv
`timescale 1ns/1ps
module qdec_frontend_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ctrl = 16'h0000;
  logic        pa = 1'b0, pb = 1'b0, pi = 1'b0, ps = 1'b0;
  logic        cnt_pulse, cnt_dir, phase_err;
  logic        idx_lvl, idx_rise, idx_fall, stb_lvl, stb_rise, stb_fall;

  int total = 0;
  int bad   = 0;
  int slot  = 0;
  bit done  = 0;

  // expected bits: {pulse, dir, err, il, ir, if, sl, sr, sf}
  logic [8:0] exp_q[$];
  int         due_q[$];
  string      tag_q[$];

  // model history of conditioned lanes {s, i, b, a}
  logic [3:0] mprev;

  always #2.5 clk = ~clk;

  qdec_frontend u_qdec_frontend (
    .clk(clk), .rst(rst), .ctrl_word(ctrl),
    .enc_a(pa), .enc_b(pb), .enc_idx(pi), .enc_stb(ps),
    .cnt_pulse(cnt_pulse), .cnt_dir(cnt_dir), .phase_err(phase_err),
    .idx_lvl(idx_lvl), .idx_rise(idx_rise), .idx_fall(idx_fall),
    .stb_lvl(stb_lvl), .stb_rise(stb_rise), .stb_fall(stb_fall)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // conditioned lanes from pins and control word (R2, R9, R10)
  function automatic logic [3:0] cond(input logic a, b, i, s, input logic [15:0] c);
    logic ca, cb;
    ca = a ^ c[8];
    cb = b ^ c[7];
    if (c[10]) return {s ^ c[5], i ^ c[6], ca, cb};
    return {s ^ c[5], i ^ c[6], cb, ca};
  endfunction

  task automatic step(input logic a, b, i, s, input string tag);
    logic [3:0] cur;
    logic       pl, dr, er, qa;
    logic [3:0] seq;
    @(negedge clk);
    pa = a; pb = b; pi = i; ps = s;
    cur = cond(a, b, i, s, ctrl);
    pl = 0; dr = 0; er = 0;
    if (ctrl[15:14] == 2'd0) begin
      seq = {mprev[0], mprev[1], cur[0], cur[1]};  // {prevA, prevB, curA, curB}
      case (seq)
        4'b0010, 4'b1011, 4'b1101, 4'b0100: begin pl = 1; dr = 1; end
        4'b1000, 4'b1110, 4'b0111, 4'b0001: begin pl = 1; dr = 0; end
        4'b0011, 4'b1100, 4'b0110, 4'b1001: er = 1;
        default: ;
      endcase
    end else begin
      qa = ctrl[11] ? (cur[0] && !mprev[0]) : (cur[0] != mprev[0]);
      pl = qa;
      case (ctrl[15:14])
        2'd1:    dr = cur[1];
        2'd2:    dr = 1;
        default: dr = 0;
      endcase
    end
    exp_q.push_back({pl, dr, er, cur[2], cur[2] & ~mprev[2], ~cur[2] & mprev[2],
                     cur[3], cur[3] & ~mprev[3], ~cur[3] & mprev[3]});
    due_q.push_back(slot + 2);
    tag_q.push_back(tag);
    mprev = cur;
  endtask

  task automatic set_cfg(input logic [15:0] v);
    repeat (3) @(negedge clk);
    ctrl = v;
    repeat (3) @(negedge clk);
    mprev = cond(pa, pb, pi, ps, ctrl);
  endtask

  // monitor: one slot per rising edge, 1 ns after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      slot++;
      if (due_q.size() > 0 && due_q[0] == slot) begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        void'(due_q.pop_front());
        t = tag_q.pop_front();
        chk(t, "cnt_pulse", cnt_pulse, e[8]);
        if (e[8]) chk(t, "cnt_dir", cnt_dir, e[7]);
        chk(t, "phase_err", phase_err, e[6]);
        chk(t, "idx_lvl", idx_lvl, e[5]);
        chk(t, "idx_rise", idx_rise, e[4]);
        chk(t, "idx_fall", idx_fall, e[3]);
        chk(t, "stb_lvl", stb_lvl, e[2]);
        chk(t, "stb_rise", stb_rise, e[1]);
        chk(t, "stb_fall", stb_fall, e[0]);
      end
    end
  end

  task automatic fwd(input string tag);
    step(1, 0, 0, 0, tag); step(1, 1, 0, 0, tag);
    step(0, 1, 0, 0, tag); step(0, 0, 0, 0, tag);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "cnt_pulse", cnt_pulse, 0);
    chk("R1", "phase_err", phase_err, 0);
    chk("R1", "cnt_dir", cnt_dir, 0);
    chk("R1", "idx_lvl", idx_lvl, 0);
    chk("R1", "stb_rise", stb_rise, 0);
    @(negedge clk) rst = 0;
    repeat (4) @(negedge clk);
    mprev = cond(pa, pb, pi, ps, ctrl);

    // R3 A leads B, two cycles
    fwd("R3"); fwd("R3");
    // R4 B leads A
    step(0, 1, 0, 0, "R4"); step(1, 1, 0, 0, "R4");
    step(1, 0, 0, 0, "R4"); step(0, 0, 0, 0, "R4");
    // R5 both phases change at once
    step(1, 1, 0, 0, "R5"); step(0, 0, 0, 0, "R5"); step(0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, "R5"); step(0, 1, 0, 0, "R5"); step(0, 0, 0, 0, "R5");
    // R2 unused bits set, still quadrature with no swap or inversion
    set_cfg(16'h321F);
    fwd("R2");
    // R10 exchange reverses the count
    set_cfg(16'h0400);
    fwd("R10");
    // R9 invert A lane, and B lane
    set_cfg(16'h0100);
    fwd("R9");
    set_cfg(16'h0180);
    fwd("R9");
    // R8 quadrature ignores rising-only
    set_cfg(16'h0800);
    fwd("R8");
    // R6 clock plus direction, both edges
    set_cfg(16'h4000);
    step(0, 1, 0, 0, "R6"); step(1, 1, 0, 0, "R6"); step(0, 1, 0, 0, "R6");
    step(0, 0, 0, 0, "R6"); step(1, 0, 0, 0, "R6"); step(0, 0, 0, 0, "R6");
    // R8 clock plus direction, rising only
    set_cfg(16'h4800);
    step(1, 1, 0, 0, "R8"); step(0, 1, 0, 0, "R8"); step(1, 0, 0, 0, "R8");
    step(0, 0, 0, 0, "R8");
    // R7 up counting, rising only, B toggling
    set_cfg(16'h8800);
    step(1, 0, 0, 0, "R7"); step(0, 1, 0, 0, "R7"); step(1, 1, 0, 0, "R7");
    step(0, 0, 0, 0, "R7");
    // R7 down counting, both edges
    set_cfg(16'hC000);
    step(1, 1, 0, 0, "R7"); step(0, 0, 0, 0, "R7"); step(1, 0, 0, 0, "R7");
    step(1, 1, 0, 0, "R7"); step(0, 1, 0, 0, "R7");
    // R11 index and strobe marks, plain then inverted
    set_cfg(16'h0000);
    step(0, 0, 1, 0, "R11"); step(0, 0, 1, 1, "R11"); step(0, 0, 0, 1, "R11");
    step(0, 0, 0, 0, "R11"); step(0, 0, 1, 1, "R11"); step(0, 0, 0, 0, "R11");
    set_cfg(16'h0060);
    step(0, 0, 1, 0, "R11"); step(0, 0, 0, 1, "R11"); step(0, 0, 0, 0, "R11");

    // R12 first sample after reset, every lane inverted, yields no pulse
    repeat (4) @(negedge clk);
    rst = 1; ctrl = 16'h01E0; pa = 0; pb = 0; pi = 0; ps = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk("R12", "cnt_pulse", cnt_pulse, 0);
      chk("R12", "phase_err", phase_err, 0);
      chk("R12", "idx_rise", idx_rise, 0);
      chk("R12", "stb_fall", stb_fall, 0);
    end
    chk("R12", "idx_lvl", idx_lvl, 1);
    chk("R12", "stb_lvl", stb_lvl, 1);
    chk("R12", "pending", due_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule